// File: doc/BRIEF.md
# Clock and Voltage Operating-Point Sequencer

This block moves a processor core from one operating point to another. An operating point is a clock level index together with a core-supply code for an 8-bit voltage DAC. A policy agent elsewhere picks a target level and pulses a request. The sequencer first limits that target to the window of levels that attached clients currently accept. It then tells the clients a change is coming. Next it performs three actions in an order set by the direction of the move: the memory timing profile, the voltage code and the clock level. Last, it tells the clients the change is complete.

When the core goes faster, the memory timings are loosened first, the supply is raised next and the clock moves last. When the core slows down, the clock drops first, then the supply, and the memory timings are tightened last. After each voltage write a programmable settle count runs out before the sequence goes on. After each clock write a separate lock count runs out. The block also outputs the delay-loop calibration constant for the current level. It computes this value from a base value rather than measuring it again.

The request pin is a plain strobe with no back-pressure. A strobe is taken only when `busy` is low. A strobe that arrives while `busy` is high is dropped and flagged with `reject`, so the requester has to retry once `done` has been seen.

Top module: `dvfs_seq`

## Requirements
- R1: After reset, clk_level is 0, vdac_code is 96 (the code for level 0), mem_relaxed is 0 (tight profile), and busy, done, pre_notify, post_notify and reject are all 0.
- R2: An accepted request is clamped in this order: first to lim_max, then up to lim_min, then to level 11. If the limits cross, lim_min therefore wins. The limits are sampled one cycle after the request is taken.
- R3: On a move to a higher level, mem_relaxed becomes 1 first, then vdac_code rises, then clk_level rises. Each of these changes happens in a different cycle.
- R4: On a move to a lower level, clk_level falls first, then vdac_code falls, then mem_relaxed becomes 0. Each of these changes happens in a different cycle.
- R5: While the block is idle, vdac_code equals 96 + 12 × clk_level. This code never decreases as the level rises.
- R6: After a vdac_code change, the next action waits at least settle_cycles cycles. After a clk_level change, the next action waits at least lock_cycles cycles.
- R7: When the level changes, pre_notify pulses exactly once before the first action. post_notify pulses exactly once after the clock change, and done follows it. The two notifications are never high in the same cycle.
- R8: If the clamped target equals the current level, done pulses without any notification, and vdac_code, clk_level and mem_relaxed all stay unchanged.
- R9: A req_valid strobe that arrives while busy is high has no effect on the sequence in progress. It raises reject for exactly one cycle, in the cycle that follows the strobe.
- R10: lpj_value always equals lpj_base × (clk_level + 4).
- R11: done is a one-cycle pulse. busy goes high the cycle after a request is taken and stays high through the cycle in which done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe for a level change |
| req_level | input | 4 | Requested level index |
| lim_min | input | 4 | Lowest level clients accept |
| lim_max | input | 4 | Highest level clients accept |
| settle_cycles | input | 8 | Wait after a voltage write |
| lock_cycles | input | 8 | Wait after a clock write |
| lpj_base | input | 16 | Calibration constant per unit of frequency multiplier |
| vdac_code | output | 8 | Core-supply DAC code |
| clk_level | output | 4 | Clock level select |
| mem_relaxed | output | 1 | 1 = relaxed memory timings, 0 = tight |
| pre_notify | output | 1 | Pulse: a change is about to happen |
| post_notify | output | 1 | Pulse: the new clock is in effect |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | Pulse: the request is finished |
| reject | output | 1 | Pulse: a request was dropped while busy |
| lpj_value | output | 20 | Scaled delay-loop constant |

## Verification
The assertions check, on every cycle, the ordering rules that must hold at any edge where an output changes. They check that the clock never rises unless the relaxed profile and a high enough supply are already in place, and that the supply never falls while the clock is still above the new code. They also check that the supply code matches the level whenever the block is idle, that the calibration product is correct, and that the done, reject and notification pulses are well formed. Only the directed scenarios can show the full sequences: the order of events over a whole transition, the settle and lock gaps measured in cycles, the clamping results for specific limit windows, and the silent completion of a request for the current level.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_CLAMP, S_PRE, S_STEP1, S_STEP2, S_STEP3, S_POST, S_DONE
  } seq_state_t;

  typedef enum logic [1:0] {
    A_MEM, A_VOLT, A_CLK
  } seq_act_t;

  // Supply code for a level, saturating at the 8-bit ceiling.
  function automatic logic [7:0] vcode_of(input int base, input int step, input int lvl);
    int v;
    v = base + step * lvl;
    if (v > 255) v = 255;
    return v[7:0];
  endfunction
endpackage

// File: rtl/dvfs_clamp.sv
module dvfs_clamp #(
  parameter int NLEVELS = 12,
  localparam int LW = $clog2(NLEVELS)
) (
  input  logic [LW-1:0] req,
  input  logic [LW-1:0] lo,
  input  logic [LW-1:0] hi,
  output logic [LW-1:0] tgt
);
  localparam logic [LW-1:0] TOP = LW'(NLEVELS - 1);
  logic [LW-1:0] a, b;
  always_comb begin
    a   = (req > hi) ? hi : req;
    b   = (a < lo) ? lo : a;
    tgt = (b > TOP) ? TOP : b;
  end
endmodule

// File: rtl/dvfs_vtable.sv
module dvfs_vtable #(
  parameter int NLEVELS = 12,
  parameter int VBASE   = 96,
  parameter int VSTEP   = 12,
  localparam int LW = $clog2(NLEVELS)
) (
  input  logic [LW-1:0] sel,
  output logic [7:0]    code
);
  import dvfs_pkg::*;
  logic [7:0] tbl [NLEVELS];
  for (genvar gi = 0; gi < NLEVELS; gi++) begin : g_row
    assign tbl[gi] = vcode_of(VBASE, VSTEP, gi);
  end
  assign code = (int'(sel) < NLEVELS) ? tbl[sel] : tbl[NLEVELS-1];
endmodule

// File: rtl/dvfs_wait_timer.sv
module dvfs_wait_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end
  assign expired = (cnt == '0);
endmodule

// File: rtl/dvfs_seq.sv
module dvfs_seq #(
  parameter int NLEVELS  = 12,
  parameter int VBASE    = 96,
  parameter int VSTEP    = 12,
  parameter int CW       = 8,
  parameter int LPJ_W    = 16,
  parameter int MULT_OFS = 4,
  localparam int LW      = $clog2(NLEVELS),
  localparam int LPJ_OW  = LPJ_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [LW-1:0]     req_level,
  input  logic [LW-1:0]     lim_min,
  input  logic [LW-1:0]     lim_max,
  input  logic [CW-1:0]     settle_cycles,
  input  logic [CW-1:0]     lock_cycles,
  input  logic [LPJ_W-1:0]  lpj_base,
  output logic [7:0]        vdac_code,
  output logic [LW-1:0]     clk_level,
  output logic              mem_relaxed,
  output logic              pre_notify,
  output logic              post_notify,
  output logic              busy,
  output logic              done,
  output logic              reject,
  output logic [LPJ_OW-1:0] lpj_value
);
  import dvfs_pkg::*;

  seq_state_t    state;
  logic [LW-1:0] req_q, tgt_q, cur_q, clamped;
  logic [7:0]    vdac_q, tgt_code;
  logic          mem_q, up_q, launched, reject_q;
  logic          tim_load, tim_expired;
  logic [CW-1:0] tim_val;
  seq_act_t      act;

  dvfs_clamp #(.NLEVELS(NLEVELS)) clamp_i (
    .req(req_q), .lo(lim_min), .hi(lim_max), .tgt(clamped));

  dvfs_vtable #(.NLEVELS(NLEVELS), .VBASE(VBASE), .VSTEP(VSTEP)) vtab_i (
    .sel(tgt_q), .code(tgt_code));

  dvfs_wait_timer #(.CW(CW)) timer_i (
    .clk(clk), .rst_n(rst_n), .load(tim_load), .load_val(tim_val),
    .expired(tim_expired));

  // Action for the current step; the sequence reverses with direction.
  always_comb begin
    act = A_VOLT;
    unique case (state)
      S_STEP1: act = up_q ? A_MEM : A_CLK;
      S_STEP3: act = up_q ? A_CLK : A_MEM;
      default: act = A_VOLT;
    endcase
  end

  always_comb begin
    tim_load = 1'b0;
    tim_val  = '0;
    if ((state == S_STEP1 || state == S_STEP2 || state == S_STEP3) && !launched) begin
      tim_load = 1'b1;
      unique case (act)
        A_VOLT:  tim_val = settle_cycles;
        A_CLK:   tim_val = lock_cycles;
        default: tim_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      req_q    <= '0;
      tgt_q    <= '0;
      cur_q    <= '0;
      vdac_q   <= vcode_of(VBASE, VSTEP, 0);
      mem_q    <= 1'b0;
      up_q     <= 1'b0;
      launched <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      reject_q <= req_valid && (state != S_IDLE);
      unique case (state)
        S_IDLE: if (req_valid) begin
          req_q <= req_level;
          state <= S_CLAMP;
        end
        S_CLAMP: begin
          tgt_q <= clamped;
          up_q  <= clamped > cur_q;
          state <= (clamped == cur_q) ? S_DONE : S_PRE;
        end
        S_PRE: state <= S_STEP1;
        S_STEP1, S_STEP2, S_STEP3: begin
          if (!launched) begin
            launched <= 1'b1;
            unique case (act)
              A_MEM:   mem_q  <= up_q;
              A_VOLT:  vdac_q <= tgt_code;
              default: cur_q  <= tgt_q;
            endcase
          end else if (tim_expired) begin
            launched <= 1'b0;
            state <= (state == S_STEP1) ? S_STEP2 :
                     (state == S_STEP2) ? S_STEP3 : S_POST;
          end
        end
        S_POST:  state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign vdac_code   = vdac_q;
  assign clk_level   = cur_q;
  assign mem_relaxed = mem_q;
  assign pre_notify  = (state == S_PRE);
  assign post_notify = (state == S_POST);
  assign done        = (state == S_DONE);
  assign busy        = (state != S_IDLE);
  assign reject      = reject_q;
  assign lpj_value   = LPJ_OW'(lpj_base) * LPJ_OW'(int'(cur_q) + MULT_OFS);
endmodule

// File: rtl/dvfs_seq_chk.sv
module dvfs_seq_chk #(
  parameter int NLEVELS  = 12,
  parameter int VBASE    = 96,
  parameter int VSTEP    = 12,
  parameter int LPJ_W    = 16,
  parameter int MULT_OFS = 4,
  localparam int LW      = $clog2(NLEVELS),
  localparam int LPJ_OW  = LPJ_W + 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [LW-1:0]     clk_level,
  input logic [7:0]        vdac_code,
  input logic              mem_relaxed,
  input logic              pre_notify,
  input logic              post_notify,
  input logic              busy,
  input logic              done,
  input logic              reject,
  input logic [LPJ_W-1:0]  lpj_base,
  input logic [LPJ_OW-1:0] lpj_value
);
  int code_now;
  assign code_now = VBASE + VSTEP * int'(clk_level);

  assert_clk_up_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_level > $past(clk_level)) |-> (mem_relaxed && int'(vdac_code) >= code_now));

  assert_volt_down_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vdac_code < $past(vdac_code)) |-> (int'(vdac_code) >= code_now));

  assert_idle_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (int'(vdac_code) == code_now));

  assert_notify_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pre_notify && post_notify));

  assert_post_then_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    post_notify |=> done);

  assert_idle_level_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(clk_level));

  assert_reject_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> ($past(req_valid) && $past(busy)));

  assert_lpj_product_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lpj_value == LPJ_OW'(int'(lpj_base) * (int'(clk_level) + MULT_OFS)));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy ##1 !done));
endmodule

bind dvfs_seq dvfs_seq_chk #(
  .NLEVELS(NLEVELS), .VBASE(VBASE), .VSTEP(VSTEP),
  .LPJ_W(LPJ_W), .MULT_OFS(MULT_OFS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .clk_level(clk_level),
  .vdac_code(vdac_code), .mem_relaxed(mem_relaxed), .pre_notify(pre_notify),
  .post_notify(post_notify), .busy(busy), .done(done), .reject(reject),
  .lpj_base(lpj_base), .lpj_value(lpj_value)
);

// File: tb/dvfs_seq_tb.sv
module dvfs_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [3:0] req_level = '0, lim_min = '0, lim_max = 4'd11;
  logic [7:0] settle_cycles = 8'd5, lock_cycles = 8'd3;
  logic [15:0] lpj_base = 16'd1000;
  logic [7:0] vdac_code;
  logic [3:0] clk_level;
  logic mem_relaxed, pre_notify, post_notify, busy, done, reject;
  logic [19:0] lpj_value;

  always #4 clk = ~clk;

  dvfs_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
    .lim_min(lim_min), .lim_max(lim_max), .settle_cycles(settle_cycles),
    .lock_cycles(lock_cycles), .lpj_base(lpj_base), .vdac_code(vdac_code),
    .clk_level(clk_level), .mem_relaxed(mem_relaxed), .pre_notify(pre_notify),
    .post_notify(post_notify), .busy(busy), .done(done), .reject(reject),
    .lpj_value(lpj_value));

  int n_tests = 0, n_fail = 0;
  int cyc = 0;
  // Event log: 1 mem, 2 vdac, 3 clk, 4 pre, 5 post, 6 done, 7 reject
  int ev_code [64];
  int ev_time [64];
  int n_ev = 0;
  logic [7:0] p_vdac;
  logic [3:0] p_lvl;
  logic p_mem;
  logic mon_on = 1'b0;

  function automatic int vexp(input int l);
    return 96 + 12 * l;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic log_ev(input int c);
    if (n_ev < 64) begin
      ev_code[n_ev] = c;
      ev_time[n_ev] = cyc;
      n_ev++;
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (mon_on) begin
      if (mem_relaxed != p_mem) log_ev(1);
      if (vdac_code != p_vdac) log_ev(2);
      if (clk_level != p_lvl) log_ev(3);
      if (pre_notify) log_ev(4);
      if (post_notify) log_ev(5);
      if (done) log_ev(6);
      if (reject) log_ev(7);
    end
    p_mem = mem_relaxed; p_vdac = vdac_code; p_lvl = clk_level;
  end

  int ev_seen[8];
  int ev_at[8];
  task automatic summarize();
    for (int k = 0; k < 8; k++) begin ev_seen[k] = 0; ev_at[k] = -1; end
    for (int k = 0; k < n_ev; k++) begin
      ev_seen[ev_code[k]]++;
      if (ev_at[ev_code[k]] < 0) ev_at[ev_code[k]] = ev_time[k];
    end
  endtask

  task automatic request(input int lvl);
    @(negedge clk);
    n_ev = 0;
    mon_on = 1'b1;
    req_level = 4'(lvl);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    int t;
    t = 0;
    while (!done && t < 2000) begin @(negedge clk); t++; end
    if (t >= 2000) chk("R11 watchdog", 0, 1);
    @(negedge clk);
    @(negedge clk);
    summarize();
  endtask

  task automatic t_reset();
    chk("R1 level", clk_level, 0);
    chk("R1 vdac", vdac_code, 96);
    chk("R1 mem", mem_relaxed, 0);
    chk("R1 idle", {busy, done, pre_notify, post_notify, reject}, 0);
    chk("R10 lpj reset", lpj_value, 4000);
  endtask

  task automatic t_up();
    request(6);
    chk("R11 busy after accept", busy, 1);
    wait_done();
    chk("R3 mem before vdac", int'(ev_at[1] < ev_at[2]), 1);
    chk("R3 vdac before clk", int'(ev_at[2] < ev_at[3]), 1);
    chk("R7 pre before first action", int'(ev_at[4] < ev_at[1]), 1);
    chk("R7 post after clk", int'(ev_at[5] > ev_at[3]), 1);
    chk("R7 one pre", ev_seen[4], 1);
    chk("R7 one post", ev_seen[5], 1);
    chk("R11 one done", ev_seen[6], 1);
    chk("R6 settle gap", int'(ev_at[3] - ev_at[2] >= 5), 1);
    chk("R5 vdac lvl6", vdac_code, vexp(6));
    chk("R3 level", clk_level, 6);
    chk("R3 mem relaxed", mem_relaxed, 1);
    chk("R10 lpj lvl6", lpj_value, 10000);
    chk("R11 idle after", busy, 0);
  endtask

  task automatic t_down();
    lock_cycles = 8'd9;
    request(2);
    wait_done();
    chk("R4 clk before vdac", int'(ev_at[3] < ev_at[2]), 1);
    chk("R4 vdac before mem", int'(ev_at[2] < ev_at[1]), 1);
    chk("R6 lock gap", int'(ev_at[2] - ev_at[3] >= 9), 1);
    chk("R4 level", clk_level, 2);
    chk("R5 vdac lvl2", vdac_code, vexp(2));
    chk("R4 mem tight", mem_relaxed, 0);
    lock_cycles = 8'd3;
  endtask

  task automatic t_clamp();
    lim_min = 4'd1; lim_max = 4'd7;
    request(11);
    wait_done();
    chk("R2 clamp to max", clk_level, 7);
    request(0);
    wait_done();
    chk("R2 clamp to min", clk_level, 1);
    lim_min = 4'd9; lim_max = 4'd4;
    request(0);
    wait_done();
    chk("R2 crossed limits min wins", clk_level, 9);
    lim_min = 4'd0; lim_max = 4'd15;
    request(15);
    wait_done();
    chk("R2 cap at 11", clk_level, 11);
    chk("R5 vdac lvl11", vdac_code, vexp(11));
    lim_max = 4'd11;
  endtask

  task automatic t_same();
    request(11);
    wait_done();
    chk("R8 done seen", ev_seen[6], 1);
    chk("R8 no notifications", ev_seen[4] + ev_seen[5], 0);
    chk("R8 no output change", ev_seen[1] + ev_seen[2] + ev_seen[3], 0);
    chk("R8 level kept", clk_level, 11);
  endtask

  task automatic t_reject();
    request(3);
    repeat (3) @(negedge clk);
    req_level = 4'd8;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 reject pulse", reject, 1);
    @(negedge clk);
    chk("R9 reject one cycle", reject, 0);
    wait_done();
    chk("R9 level from first request", clk_level, 3);
    chk("R9 one reject event", ev_seen[7], 1);
    chk("R5 vdac lvl3", vdac_code, vexp(3));
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_up();
        t_down();
        t_clamp();
        t_same();
        t_reject();
      end
      begin
        repeat (100000) @(negedge clk);
        chk("R11 global watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule